// File: doc/BRIEF.md
# Test Operand Pattern Generator

This block supplies 16-bit operand words to a processor self-test harness. The harness starts a run, chooses one of two sources, and then pulls words one at a time with a single-cycle request. Each run is divided into sets. A set holds `WORDS_PER_SET` words, one for each register pair the harness fills before it executes an instruction under test.

In systematic mode the run covers sixteen fixed edge-case words, one word per set. Every word of a set carries that set's pattern, so all register pairs start with the same value. In pseudo-random mode an 8-bit shift-register generator produces the words, two draws per word. The generator is modified so that it passes through all 256 byte values, the all-zero byte included. Successive words therefore differ, and each register pair gets its own value. The number of random sets per run is programmable.

The generator can be seeded. Starting a run does not reseed it, so consecutive random runs see fresh data.

Top module: `operand_pattern_gen`

## Requirements
- R1: While reset is asserted, and after it is released, `valid_o`, `last_in_set_o` and `last_in_run_o` are low and `word_o` is 0. A request before the first start produces no word.
- R2: A request accepted on a clock edge gives `valid_o` high for exactly that one following cycle, with the new word on `word_o`. With no accepted request, `valid_o` is low.
- R3: In systematic mode (`mode_i`=0), set k (k = 0 to 15) delivers word k of this list, in order: 0000, FFFF, 00FF, FF00, 0F0F, F0F0, 3333, CCCC, 5555, AAAA, 55AA, AA55, 33CC, CC33, FF55, 00AA (hex).
- R4: Each set holds `WORDS_PER_SET` words. In systematic mode every word of a set is the same. `last_in_set_o` is high with the final word of each set and low otherwise.
- R5: The generator steps from state s to {s[6:0], f}. Here f = s[7]^s[5]^s[4]^s[3], and f is inverted when s[6:0] is all zero. Starting from any seed, 256 consecutive draws cover all 256 byte values.
- R6: In random mode (`mode_i`=1) each word takes two draws. The first draw is the high byte and the second is the low byte. The generator ends on the second draw, so consecutive words within a set differ.
- R7: A random run holds `set_count_i` sets, sampled at start. A count of 0 is treated as 1, and counts above 239 are treated as 239. A systematic run always holds 16 sets. `last_in_run_o` is high only with the final word of the run.
- R8: A seed load sets the generator state to `seed_i`, so the next random word is {step(seed), step(step(seed))}. A start never reseeds the generator, so back-to-back random runs begin with different words.
- R9: A request in the same cycle as a start or a seed load is dropped (no valid word follows). A seed load does not change the position within the run.
- R10: A start while a run is active restarts at set 0, word 0. After the final word of a run, requests are ignored until the next start.
- R11: Systematic runs and idle cycles leave the generator state untouched. A random word taken after a systematic run continues from where the generator was left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that begins a run |
| mode_i | input | 1 | Source sampled at start: 0 systematic, 1 pseudo-random |
| set_count_i | input | 8 | Random sets per run, sampled at start (clamped to 1..239) |
| seed_load_i | input | 1 | One-cycle pulse that loads the generator state |
| seed_i | input | 8 | Generator seed value |
| req_i | input | 1 | Next-word request, one per cycle at most |
| word_o | output | 16 | Current operand word, held until the next one |
| valid_o | output | 1 | Pulses for one cycle when a new word is presented |
| last_in_set_o | output | 1 | New word is the last of its set |
| last_in_run_o | output | 1 | New word is the last of the run |

## Verification
The assertions assume that the inputs are free of X after reset. They also assume that start, seed load and request are each sampled only on the clock edge where they are high, so a pulse lasting several cycles counts as several events. The mode and the set count matter only in a start cycle. The bench changes every input only on the falling clock edge and raises start and seed load for one cycle at a time. It deliberately makes start or seed load coincide with a request to exercise the drop rule.

// File: rtl/opg_pkg.sv
package opg_pkg;

    localparam int BYTE_W        = 8;
    localparam int WORD_W        = 2 * BYTE_W;
    localparam int SET_W         = 8;
    localparam int SYS_WORDS     = 16;
    localparam int MAX_RAND_SETS = 239;

    typedef enum logic {
        MODE_SYS  = 1'b0,
        MODE_RAND = 1'b1
    } opg_mode_e;

    // One generator step: shift left, new bit from taps 8,6,5,4,
    // feedback flipped when the seven retained bits are all zero.
    function automatic logic [BYTE_W-1:0] gen_step(input logic [BYTE_W-1:0] s);
        logic fb;
        fb = s[7] ^ s[5] ^ s[4] ^ s[3];
        if (s[6:0] == 7'd0) begin
            fb = ~fb;
        end
        return {s[6:0], fb};
    endfunction

    function automatic logic [SET_W-1:0] clamp_sets(input logic [SET_W-1:0] n);
        logic [SET_W-1:0] r;
        if (n == '0) begin
            r = SET_W'(1);
        end else if (n > SET_W'(MAX_RAND_SETS)) begin
            r = SET_W'(MAX_RAND_SETS);
        end else begin
            r = n;
        end
        return r;
    endfunction

endpackage

// File: rtl/opg_lfsr.sv
module opg_lfsr
    import opg_pkg::*;
#(
    parameter logic [BYTE_W-1:0] SEED_RESET = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] seed_i,
    input  logic              adv_i,
    output logic [BYTE_W-1:0] state_o,
    output logic [WORD_W-1:0] word_o
);

    typedef struct packed {
        logic [BYTE_W-1:0] state;
    } gen_reg_t;

    gen_reg_t          gen_d, gen_q;
    logic [BYTE_W-1:0] draw_hi, draw_lo;

    always_comb begin
        draw_hi = gen_step(gen_q.state);
        draw_lo = gen_step(draw_hi);
        gen_d   = gen_q;
        if (load_i) begin
            gen_d.state = seed_i;
        end else if (adv_i) begin
            gen_d.state = draw_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gen_q.state <= SEED_RESET;
        end else begin
            gen_q <= gen_d;
        end
    end

    assign state_o = gen_q.state;
    assign word_o  = {draw_hi, draw_lo};

endmodule

// File: rtl/opg_pattern_table.sv
module opg_pattern_table
    import opg_pkg::*;
(
    input  logic [SET_W-1:0]  idx_i,
    output logic [WORD_W-1:0] word_o
);

    always_comb begin
        case (idx_i)
            8'd0:    word_o = 16'h0000;
            8'd1:    word_o = 16'hFFFF;
            8'd2:    word_o = 16'h00FF;
            8'd3:    word_o = 16'hFF00;
            8'd4:    word_o = 16'h0F0F;
            8'd5:    word_o = 16'hF0F0;
            8'd6:    word_o = 16'h3333;
            8'd7:    word_o = 16'hCCCC;
            8'd8:    word_o = 16'h5555;
            8'd9:    word_o = 16'hAAAA;
            8'd10:   word_o = 16'h55AA;
            8'd11:   word_o = 16'hAA55;
            8'd12:   word_o = 16'h33CC;
            8'd13:   word_o = 16'hCC33;
            8'd14:   word_o = 16'hFF55;
            8'd15:   word_o = 16'h00AA;
            default: word_o = 16'h0000;
        endcase
    end

endmodule

// File: rtl/opg_sequencer.sv
module opg_sequencer
    import opg_pkg::*;
#(
    parameter int WORDS_PER_SET = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  opg_mode_e        mode_i,
    input  logic [SET_W-1:0] set_count_i,
    input  logic             take_i,
    output logic             active_o,
    output opg_mode_e        mode_o,
    output logic [SET_W-1:0] set_idx_o,
    output logic             last_word_o,
    output logic             last_set_o
);

    localparam int WIDX_W = (WORDS_PER_SET > 1) ? $clog2(WORDS_PER_SET) : 1;
    localparam logic [WIDX_W-1:0] WIDX_LAST = WIDX_W'(WORDS_PER_SET - 1);

    typedef struct packed {
        logic              active;
        opg_mode_e         mode;
        logic [SET_W-1:0]  lim;
        logic [SET_W-1:0]  set_idx;
        logic [WIDX_W-1:0] widx;
    } seq_reg_t;

    seq_reg_t seq_d, seq_q;
    logic     at_last_word, at_last_set;

    assign at_last_word = (seq_q.widx == WIDX_LAST);
    assign at_last_set  = (seq_q.set_idx == seq_q.lim - SET_W'(1));

    always_comb begin
        seq_d = seq_q;
        if (start_i) begin
            seq_d.active  = 1'b1;
            seq_d.mode    = mode_i;
            seq_d.lim     = (mode_i == MODE_RAND) ? clamp_sets(set_count_i)
                                                  : SET_W'(SYS_WORDS);
            seq_d.set_idx = '0;
            seq_d.widx    = '0;
        end else if (take_i) begin
            if (at_last_word) begin
                seq_d.widx = '0;
                if (at_last_set) begin
                    seq_d.active = 1'b0;
                end else begin
                    seq_d.set_idx = seq_q.set_idx + SET_W'(1);
                end
            end else begin
                seq_d.widx = seq_q.widx + WIDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.active  <= 1'b0;
            seq_q.mode    <= MODE_SYS;
            seq_q.lim     <= SET_W'(1);
            seq_q.set_idx <= '0;
            seq_q.widx    <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign active_o    = seq_q.active;
    assign mode_o      = seq_q.mode;
    assign set_idx_o   = seq_q.set_idx;
    assign last_word_o = at_last_word;
    assign last_set_o  = at_last_set;

endmodule

// File: rtl/operand_pattern_gen.sv
module operand_pattern_gen
    import opg_pkg::*;
#(
    parameter int                WORDS_PER_SET = 4,
    parameter logic [BYTE_W-1:0] SEED_RESET    = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [SET_W-1:0]  set_count_i,
    input  logic              seed_load_i,
    input  logic [BYTE_W-1:0] seed_i,
    input  logic              req_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              last_in_set_o,
    output logic              last_in_run_o
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              valid;
        logic              last_set;
        logic              last_run;
    } out_reg_t;

    out_reg_t          out_d, out_q;
    logic              take;
    logic              lfsr_adv;
    logic              run_active;
    opg_mode_e         run_mode;
    logic [SET_W-1:0]  set_idx;
    logic              last_word, last_set;
    logic [BYTE_W-1:0] lfsr_state;
    logic [WORD_W-1:0] rand_word, sys_word;

    assign take     = req_i & run_active & ~start_i & ~seed_load_i;
    assign lfsr_adv = take & (run_mode == MODE_RAND);

    opg_sequencer #(
        .WORDS_PER_SET (WORDS_PER_SET)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mode_i      (opg_mode_e'(mode_i)),
        .set_count_i (set_count_i),
        .take_i      (take),
        .active_o    (run_active),
        .mode_o      (run_mode),
        .set_idx_o   (set_idx),
        .last_word_o (last_word),
        .last_set_o  (last_set)
    );

    opg_lfsr #(
        .SEED_RESET (SEED_RESET)
    ) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (seed_load_i),
        .seed_i  (seed_i),
        .adv_i   (lfsr_adv),
        .state_o (lfsr_state),
        .word_o  (rand_word)
    );

    opg_pattern_table u_tab (
        .idx_i  (set_idx),
        .word_o (sys_word)
    );

    always_comb begin
        out_d          = out_q;
        out_d.valid    = take;
        out_d.last_set = take & last_word;
        out_d.last_run = take & last_word & last_set;
        if (take) begin
            out_d.word = (run_mode == MODE_RAND) ? rand_word : sys_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.word     <= '0;
            out_q.valid    <= 1'b0;
            out_q.last_set <= 1'b0;
            out_q.last_run <= 1'b0;
        end else begin
            out_q <= out_d;
        end
    end

    assign word_o        = out_q.word;
    assign valid_o       = out_q.valid;
    assign last_in_set_o = out_q.last_set;
    assign last_in_run_o = out_q.last_run;

endmodule

// File: rtl/opg_checker.sv
module opg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       seed_load_i,
    input logic [7:0] seed_i,
    input logic       req_i,
    input logic       valid_o,
    input logic       last_in_set_o,
    input logic       last_in_run_o,
    input logic [7:0] lfsr_state,
    input logic       lfsr_adv
);

    // R2
    valid_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(req_i));

    // R9
    start_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !valid_o);

    // R9
    seed_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load_i |=> !valid_o);

    // R8
    seed_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load_i |=> (lfsr_state == $past(seed_i)));

    // R5
    gen_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lfsr_adv && !seed_load_i) |=> (lfsr_state != $past(lfsr_state)));

    // R11
    gen_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lfsr_adv && !seed_load_i) |=> $stable(lfsr_state));

    // R4
    set_end_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_in_set_o |-> valid_o);

    // R7
    run_end_in_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_in_run_o |-> last_in_set_o);

endmodule

bind operand_pattern_gen opg_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .seed_load_i   (seed_load_i),
    .seed_i        (seed_i),
    .req_i         (req_i),
    .valid_o       (valid_o),
    .last_in_set_o (last_in_set_o),
    .last_in_run_o (last_in_run_o),
    .lfsr_state    (lfsr_state),
    .lfsr_adv      (lfsr_adv)
);

// File: tb/operand_pattern_gen_bench.sv
module operand_pattern_gen_bench;

    localparam int WPS = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i, mode_i, seed_load_i, req_i;
    logic [7:0]  set_count_i, seed_i;
    logic [15:0] word_o;
    logic        valid_o, last_in_set_o, last_in_run_o;

    always #10 clk = ~clk;

    operand_pattern_gen u_operand_pattern_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .mode_i        (mode_i),
        .set_count_i   (set_count_i),
        .seed_load_i   (seed_load_i),
        .seed_i        (seed_i),
        .req_i         (req_i),
        .word_o        (word_o),
        .valid_o       (valid_o),
        .last_in_set_o (last_in_set_o),
        .last_in_run_o (last_in_run_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int sys_tab [16] = '{'h0000, 'hFFFF, 'h00FF, 'hFF00, 'h0F0F, 'hF0F0, 'h3333, 'hCCCC,
                         'h5555, 'hAAAA, 'h55AA, 'hAA55, 'h33CC, 'hCC33, 'hFF55, 'h00AA};

    function automatic int step8(int s);
        int fb;
        fb = ((s >> 7) ^ (s >> 5) ^ (s >> 4) ^ (s >> 3)) & 1;
        if ((s & 127) == 0) fb = fb ^ 1;
        return ((s << 1) & 255) | fb;
    endfunction

    function automatic int clampset(int n);
        if (n == 0) return 1;
        if (n > 239) return 239;
        return n;
    endfunction

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Behavioural reference model, updated on every rising edge.
    int m_lfsr, m_lim, m_set, m_wi, e_word;
    bit m_active, m_mode, e_valid, e_ls, e_lr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lfsr = 1; m_active = 0; m_mode = 0; m_lim = 1; m_set = 0; m_wi = 0;
            e_word = 0; e_valid = 0; e_ls = 0; e_lr = 0;
        end else begin
            bit take;
            take = req_i && m_active && !start_i && !seed_load_i;
            e_valid = take; e_ls = 0; e_lr = 0;
            if (take) begin
                if (m_mode) begin
                    int a, b;
                    a = step8(m_lfsr);
                    b = step8(a);
                    e_word = a * 256 + b;
                    m_lfsr = b;
                end else begin
                    e_word = sys_tab[m_set];
                end
                if (m_wi == WPS - 1) begin
                    e_ls = 1; m_wi = 0;
                    if (m_set == m_lim - 1) begin
                        e_lr = 1; m_active = 0;
                    end else begin
                        m_set++;
                    end
                end else begin
                    m_wi++;
                end
            end
            if (seed_load_i) m_lfsr = int'(seed_i);
            if (start_i) begin
                m_active = 1; m_mode = mode_i;
                m_lim = mode_i ? clampset(int'(set_count_i)) : 16;
                m_set = 0; m_wi = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(valid_o == e_valid, "R2 valid", valid_o, e_valid);
            chk(word_o == 16'(e_word), m_mode ? "R6 word" : "R3 word", word_o, e_word);
            chk(last_in_set_o == e_ls, "R4 last_in_set", last_in_set_o, e_ls);
            chk(last_in_run_o == e_lr, "R7 last_in_run", last_in_run_o, e_lr);
        end
    end

    task automatic start_run(bit m, int cnt);
        start_i = 1'b1; mode_i = m; set_count_i = 8'(cnt);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic req_one();
        req_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
    endtask

    task automatic load_seed(int v);
        seed_load_i = 1'b1; seed_i = 8'(v);
        @(negedge clk);
        seed_load_i = 1'b0;
    endtask

    task automatic finish_up();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int prev;
        int first_a;
        int lr_at;
        bit seen [256];
        int distinct;

        rst_n = 1'b0; start_i = 0; mode_i = 0; seed_load_i = 0; req_i = 0;
        set_count_i = 0; seed_i = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(valid_o == 0 && last_in_set_o == 0 && last_in_run_o == 0, "R1 flags",
            {valid_o, last_in_set_o, last_in_run_o}, 0);
        chk(word_o == 0, "R1 word", word_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        req_one();
        chk(valid_o == 0, "R1 req before start", valid_o, 0);

        // seed to zero before the systematic run (R11: it must survive)
        load_seed(0);

        // R3 / R4: full systematic run with gaps
        start_run(0, 0);
        for (int s = 0; s < 16; s++) begin
            for (int w = 0; w < WPS; w++) begin
                req_one();
                chk(valid_o == 1, "R2 valid pulse", valid_o, 1);
                chk(word_o == 16'(sys_tab[s]), "R3 pattern", word_o, sys_tab[s]);
                chk(last_in_set_o == (w == WPS - 1), "R4 set end", last_in_set_o, w == WPS - 1);
                if ((s + w) % 3 == 0) begin
                    @(negedge clk);
                    chk(valid_o == 0, "R2 one-cycle valid", valid_o, 0);
                end
            end
        end
        chk(last_in_run_o == 1 || valid_o == 0, "R7 sys run end", last_in_run_o, 1);
        req_one();
        chk(valid_o == 0, "R10 req after run end", valid_o, 0);

        // R5 / R6 / R8 / R11: random run covering a full period from seed 0
        foreach (seen[i]) seen[i] = 0;
        start_run(1, 32);
        prev = -1;
        for (int k = 0; k < 128; k++) begin
            req_one();
            if (k == 0) chk(word_o == 16'h0102, "R11 generator kept seed", word_o, 16'h0102);
            if (k > 0) chk(int'(word_o) != prev, "R6 words differ", word_o, prev);
            prev = int'(word_o);
            seen[word_o[15:8]] = 1;
            seen[word_o[7:0]]  = 1;
        end
        distinct = 0;
        foreach (seen[i]) distinct += seen[i];
        chk(distinct == 256, "R5 full period", distinct, 256);
        chk(last_in_run_o == 1, "R7 32-set run end", last_in_run_o, 1);

        // R8: no reseed between runs
        start_run(1, 1);
        req_one();
        first_a = int'(word_o);
        repeat (WPS - 1) req_one();
        start_run(1, 1);
        req_one();
        chk(int'(word_o) != first_a, "R8 no reseed on start", word_o, first_a);
        repeat (WPS - 1) req_one();

        // R7: clamp of zero count
        start_run(1, 0);
        repeat (WPS) req_one();
        chk(last_in_run_o == 1, "R7 count 0 gives one set", last_in_run_o, 1);
        req_one();
        chk(valid_o == 0, "R10 ignored after end", valid_o, 0);

        // R7: clamp of large count
        start_run(1, 250);
        lr_at = -1;
        for (int k = 1; k <= 1000 && lr_at < 0; k++) begin
            req_one();
            if (last_in_run_o) lr_at = k;
        end
        chk(lr_at == 239 * WPS, "R7 count clamp 239", lr_at, 239 * WPS);

        // R9: start and request together
        start_run(1, 5);
        req_one(); req_one();
        start_i = 1; mode_i = 0; req_i = 1;
        @(negedge clk);
        start_i = 0; req_i = 0;
        chk(valid_o == 0, "R9 start drops req", valid_o, 0);

        // R10: restart mid-run returns to set 0
        repeat (5) req_one();
        chk(word_o == 16'(sys_tab[1]), "R10 mid-run position", word_o, sys_tab[1]);
        start_run(0, 0);
        req_one();
        chk(word_o == 16'(sys_tab[0]), "R10 restart at set 0", word_o, sys_tab[0]);

        // R9 / R8: seed load with request, then word from seed 0x80
        start_run(1, 3);
        req_one();
        seed_load_i = 1; seed_i = 8'h80; req_i = 1;
        @(negedge clk);
        seed_load_i = 0; req_i = 0;
        chk(valid_o == 0, "R9 seed load drops req", valid_o, 0);
        req_one();
        chk(word_o == 16'h0001, "R8 word after seed 80", word_o, 16'h0001);
        chk(last_in_set_o == 0, "R9 seed keeps position", last_in_set_o, 0);

        repeat (3) @(negedge clk);
        finish_up();
    end

endmodule